// File: doc/BRIEF.md
# T1 Unframed All-Ones Alarm Detector

This block watches the bit stream arriving from a T1 line and flags an alarm indication signal (AIS), which is an unframed all-ones pattern. Such a pattern may be sent toward either side of an interface. It shows that the real payload has been lost upstream and that ones are being sent in its place. Each bit is used only on clocks where its valid strobe is high. A 125 microsecond frame-boundary pulse times the observation windows. An external framer supplies a loss-of-synchronization level.

Zeros are counted over a window of two frame periods, which is 250 microseconds. When the window closes, the block records whether fewer than three zeros arrived. The registered alarm bit is high only while the framer reports loss of sync and the last completed window was quiet. It drops on the next clock after either condition stops holding. The alarm is meant to drive bit 0 of a status word elsewhere in the chip.

Top module: `ais_allones_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the window phase, the zero counter and the recorded window result are cleared and `ais_o` reads 0 after that edge. `ais_o` stays 0 until the first window after reset has closed.
- R2: A window spans FRAMES_PER_WIN frame periods (default 2). The first window starts when reset is released. A window closes on the clock where `frame_pulse` is high for the FRAMES_PER_WIN-th time since the window began, and the next window starts on the following clock.
- R3: A bit counts as a zero only on clocks where `bit_vld` is 1 and `bit_in` is 0. When `bit_vld` is 0, `bit_in` has no effect on the count or on `ais_o`.
- R4: The zero count saturates at ZERO_LIMIT (default 3) and never wraps. A window with 4 or 12 zeros is treated the same as a window with 3.
- R5: A closed window qualifies for the alarm only if it held fewer than ZERO_LIMIT zeros. With the default limit, 0, 1 or 2 zeros qualify and 3 or more do not.
- R6: `ais_o` is 1 only if `sync_lost` was 1 at the previous clock edge. With `sync_lost` held at 0, `ais_o` stays 0 whatever the bit stream carries.
- R7: The recorded window result changes only when a window closes. `ais_o` shows the new result in the cycle after the edge that samples the closing `frame_pulse`. Zeros in a window still in progress do not change `ais_o`.
- R8: A zero that arrives on the same clock as the window-closing `frame_pulse` counts toward the window that is closing.
- R9: If `sync_lost` falls in the middle of a window, `ais_o` falls on the next clock. If `sync_lost` rises in the middle of a window, `ais_o` rises on the next clock when the last closed window qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Received line data bit |
| bit_vld | input | 1 | High on clocks that carry a valid received bit |
| frame_pulse | input | 1 | One-clock pulse at each 125 microsecond frame boundary |
| sync_lost | input | 1 | Level from the framer, high while frame alignment is lost |
| ais_o | output | 1 | Registered all-ones alarm status bit |

## Verification
The bench sweeps the number of valid zeros in a window from 0 to 12 while sync is lost. This separates the quiet counts 0 to 2 from the busy counts 3 and up, and the counts 4 and 12 expose a counter that wraps instead of saturating. Zeros placed at the window's end (the last one on the closing pulse) are compared with zeros at the start, and a window filled with zeros that carry no valid strobe checks that unqualified bits are ignored. Runs with sync held present, and windows where sync falls and rises mid-window, separate the sync gate from the window result. A mid-window sample taken after the first frame pulse shows that the result changes only at the window boundary.

// File: rtl/ais_pkg.sv
// Package: shared types for the all-ones alarm detector.
// Assumes: nothing beyond IEEE 1800-2017.
package ais_pkg;

    // Window result handed from the zero counter to the alarm register
    typedef struct packed {
        logic close;   // a window closes on this clock
        logic quiet;   // closing window held fewer zeros than the limit
    } win_res_t;

    // Width of a counter that must reach the value n (at least 1 bit)
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ais_win_phase.sv
// Module: ais_win_phase
// Counts frame-boundary pulses and marks the clock on which an observation
// window of FRAMES_PER_WIN frames closes.
// Assumes: frame_pulse is one clock wide and the first window starts at
// reset release.
module ais_win_phase #(
    parameter int FRAMES_PER_WIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_pulse,
    output logic win_close
);
    localparam int PH_W = (FRAMES_PER_WIN > 1) ? $clog2(FRAMES_PER_WIN) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FRAMES_PER_WIN - 1);

    logic [PH_W-1:0] phase_q;

    // Window close: the last frame boundary of the current window
    always_comb begin
        win_close = frame_pulse && (phase_q == PH_LAST);
    end

    // Phase counter: advances per frame pulse, wraps at window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (frame_pulse) begin
            if (phase_q == PH_LAST) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ais_zero_count.sv
// Module: ais_zero_count
// Saturating count of valid zero bits within the current window. On the
// closing clock it reports whether the window (including that clock's bit)
// stayed below the zero limit, then restarts from zero.
// Assumes: win_close is one clock wide; ZERO_LIMIT >= 1.
module ais_zero_count
    import ais_pkg::*;
#(
    parameter int ZERO_LIMIT = 3,
    parameter int CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             win_close,
    output win_res_t         res,
    output logic [CNT_W-1:0] zcnt
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(ZERO_LIMIT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_n;
    logic             is_zero;

    // Next count: add this clock's valid zero, holding at the limit
    always_comb begin
        is_zero = bit_vld && !bit_in;
        cnt_n   = cnt_q;
        if (is_zero && (cnt_q != SAT)) begin
            cnt_n = cnt_q + 1'b1;
        end
    end

    // Result toward the alarm register, valid on the closing clock
    always_comb begin
        res.close = win_close;
        res.quiet = (cnt_n < SAT);
    end

    // Counter register: restart at window close, else accumulate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (win_close) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

    assign zcnt = cnt_q;
endmodule

// File: rtl/ais_alarm_reg.sv
// Module: ais_alarm_reg
// Keeps the result of the last closed window and combines it with the
// loss-of-sync level into the registered alarm bit.
// Assumes: res.close is one clock wide.
module ais_alarm_reg
    import ais_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  win_res_t res,
    input  logic     sync_lost,
    output logic     quiet_o,
    output logic     ais_o
);
    logic quiet_q;
    logic quiet_d;

    // Result to hold: fresh at window close, otherwise the stored one
    always_comb begin
        quiet_d = res.close ? res.quiet : quiet_q;
    end

    // Stored window result and the alarm output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= 1'b0;
            ais_o   <= 1'b0;
        end else begin
            quiet_q <= quiet_d;
            ais_o   <= sync_lost && quiet_d;
        end
    end

    assign quiet_o = quiet_q;
endmodule

// File: rtl/ais_allones_detector.sv
// Module: ais_allones_detector (top)
// Raises the all-ones alarm while the framer reports loss of sync and the
// last completed window of FRAMES_PER_WIN frames carried fewer than
// ZERO_LIMIT valid zeros.
// Assumes: frame_pulse marks each 125 us frame boundary for one clock.
module ais_allones_detector
    import ais_pkg::*;
#(
    parameter int FRAMES_PER_WIN = 2,
    parameter int ZERO_LIMIT     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    input  logic frame_pulse,
    input  logic sync_lost,
    output logic ais_o
);
    localparam int CNT_W = cnt_width(ZERO_LIMIT);

    logic             win_close;
    win_res_t         win_res;
    logic [CNT_W-1:0] zcnt;
    logic             quiet_q;

    ais_win_phase #(
        .FRAMES_PER_WIN(FRAMES_PER_WIN)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .win_close  (win_close)
    );

    ais_zero_count #(
        .ZERO_LIMIT(ZERO_LIMIT),
        .CNT_W     (CNT_W)
    ) u_zeros (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .bit_vld  (bit_vld),
        .win_close(win_close),
        .res      (win_res),
        .zcnt     (zcnt)
    );

    ais_alarm_reg u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .res      (win_res),
        .sync_lost(sync_lost),
        .quiet_o  (quiet_q),
        .ais_o    (ais_o)
    );
endmodule

// File: rtl/ais_allones_detector_chk.sv
// Module: ais_allones_detector_chk
// Temporal checks on the alarm detector, bound into every instance.
module ais_allones_detector_chk #(
    parameter int ZERO_LIMIT = 3,
    parameter int CNT_W      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sync_lost,
    input logic             ais_o,
    input logic             win_close,
    input logic             quiet_q,
    input logic [CNT_W-1:0] zcnt
);
    // R6
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ais_o |-> $past(sync_lost));

    // R9
    sync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_lost) |=> !ais_o);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_close |=> $stable(quiet_q));

    // R2
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> (zcnt == '0));

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((zcnt == CNT_W'(ZERO_LIMIT)) && !win_close) |=> (zcnt == CNT_W'(ZERO_LIMIT)));
endmodule

bind ais_allones_detector ais_allones_detector_chk #(
    .ZERO_LIMIT(ZERO_LIMIT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_lost(sync_lost),
    .ais_o    (ais_o),
    .win_close(win_close),
    .quiet_q  (quiet_q),
    .zcnt     (zcnt)
);

// File: tb/ais_allones_detector_test.sv
// Bench: windows of 12 clocks (frame pulses on clocks 5 and 11), expected
// alarm computed from the zero count and the sync level.
module ais_allones_detector_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b1;
    logic bit_vld = 1'b0;
    logic frame_pulse = 1'b0;
    logic sync_lost = 1'b0;
    logic ais_o;

    int checks = 0;
    int errors = 0;
    bit prev_quiet = 1'b0;
    bit done = 1'b0;

    localparam int WIN = 12;
    localparam int LIMIT = 3;

    always #2.5 clk = ~clk;

    ais_allones_detector uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_in     (bit_in),
        .bit_vld    (bit_vld),
        .frame_pulse(frame_pulse),
        .sync_lost  (sync_lost),
        .ais_o      (ais_o)
    );

    task automatic chk(input string rq, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ais_o=%b expected %b at %0t", rq, act, exp, $time);
        end
    endtask

    // One window: nz valid zeros at head (or tail), other bits ones, or
    // zeros without strobe when inv is set; sync may drop at off_at and
    // return at on_at.
    task automatic window(input int nz, input bit tail, input bit inv,
                          input bit sync, input int off_at, input int on_at,
                          input string rq);
        bit zv;
        bit s;
        for (int c = 0; c < WIN; c++) begin
            zv = tail ? (c >= WIN - nz) : (c < nz);
            s  = sync;
            if (off_at >= 0 && c >= off_at && (on_at < 0 || c < on_at)) s = 1'b0;
            @(negedge clk);
            bit_in      = zv ? 1'b0 : !inv;
            bit_vld     = zv || !inv;
            frame_pulse = (c == 5) || (c == 11);
            sync_lost   = s;
            if (c == off_at) begin
                @(posedge clk); #1;
                chk("R9 drop", ais_o, 1'b0);
            end
            if (c == on_at) begin
                @(posedge clk); #1;
                chk("R9 rise", ais_o, prev_quiet);
            end
            if (c == 5 && off_at < 0) begin
                @(posedge clk); #1;
                chk("R2 R7 mid-window", ais_o, s && prev_quiet);
            end
        end
        @(posedge clk); #1;
        prev_quiet = (nz < LIMIT);
        chk(rq, ais_o, s && prev_quiet);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        sync_lost = 1'b1;
        @(posedge clk); #1;
        chk("R1 reset", ais_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first window with sync lost, alarm only after it closes
        window(0, 1'b0, 1'b0, 1'b1, -1, -1, "R1 R5 first window");
        // R5 R4: sweep zero counts with sync lost
        for (int n = 0; n <= WIN; n++) begin
            window(n, 1'b0, 1'b0, 1'b1, -1, -1, (n >= 4) ? "R4 R5 saturate" : "R5 count");
        end
        // R8: zeros at the tail, last one on the closing pulse
        window(2, 1'b1, 1'b0, 1'b1, -1, -1, "R8 tail two");
        window(3, 1'b1, 1'b0, 1'b1, -1, -1, "R8 tail three");
        window(1, 1'b1, 1'b0, 1'b1, -1, -1, "R8 tail one");
        // R3: zeros without strobe ignored
        window(0, 1'b0, 1'b1, 1'b1, -1, -1, "R3 invalid zeros");
        window(2, 1'b0, 1'b1, 1'b1, -1, -1, "R3 invalid plus two");
        // R6: sync present gates the alarm
        for (int n = 0; n <= 3; n++) begin
            window(n, 1'b0, 1'b0, 1'b0, -1, -1, "R6 sync present");
        end
        window(0, 1'b0, 1'b0, 1'b1, -1, -1, "R6 sync lost again");
        // R9: sync drops and returns inside a window
        window(0, 1'b0, 1'b0, 1'b1, 3, 8, "R9 end");
        window(5, 1'b0, 1'b0, 1'b1, 2, -1, "R9 stays low");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule